// File: doc/BRIEF.md
# Instruction Field Patch Unit

This block edits the 9-bit fields of 32-bit instruction words in a small processor core. An instruction word is laid out as condition `[31:28]`, opcode `[27:21]`, C/Z/I flags `[20:18]`, D field `[17:9]` and S field `[8:0]`. Two families of operation use that layout. A *set* operation takes the current contents of the register addressed by D, overwrites one field with the low nine bits of the S operand, and issues a register-file write one clock later. A *prefix* operation adds the D and S operand values and keeps only nine bits of the sum. It then arms a one-shot patch that rewrites the S field, the D field or the result-write address of the next instruction that arrives at decode.

The block also tracks pipeline distance after each set operation. A word rewritten by a set must not be fetched for execution within four clocks. The unit flags any fetch of that address inside this window so the core can hold off. Decode, the ALU and the register file sit outside the block.

Top module: `field_patch_unit`

## Requirements
- R1: Operation code 1 (set-S) makes `wr_data` equal `op_dval` with bits 8:0 replaced by `op_sval`, with `wr_addr` equal to `op_daddr`, in the clock after the code is presented.
- R2: Operation code 2 (set-D) makes `wr_data` equal `op_dval` with bits 17:9 replaced by `op_sval`, one clock after the code.
- R3: Operation code 3 (set-opcode) makes `wr_data` equal `op_dval` with bits 27:19 (opcode plus C and Z effect bits) replaced by `op_sval`, one clock after the code.
- R4: `wr_en` is high for exactly the one clock that follows a code of 1, 2 or 3. Codes 0 (idle), 4 to 6 (prefixes) and 7 (reserved) produce no write.
- R5: After code 4 (alter-S), the next instruction presented with `next_valid` leaves with bits 8:0 equal to (`op_dval` + `op_sval`) mod 512. Every other bit is unchanged, including the I bit 18.
- R6: After code 5 (alter-D), the next valid instruction leaves with bits 17:9 equal to (`op_dval` + `op_sval`) mod 512. Every other bit is unchanged.
- R7: After code 6 (alter-R), `result_addr` for the next valid instruction equals (`op_dval` + `op_sval`) mod 512, and the word itself passes unchanged.
- R8: With no prefix armed, `patched_insn` equals `next_insn` and `result_addr` equals `next_insn[17:9]`. Code 7 never arms anything.
- R9: An armed prefix applies to exactly one valid instruction, whatever that instruction's condition field holds. Cycles without `next_valid` keep it armed. A prefix code presented in the same cycle as a consuming instruction re-arms for the instruction after it.
- R10: After a set operation on address A presented in cycle t, `patch_hazard` is high in cycles t+1 to t+4 whenever `next_valid` is high and `next_addr` equals A. It is low from t+5, and low for any other address.
- R11: After reset, `wr_en` and `patch_hazard` are low and no prefix is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 3 | Operation this cycle (0 idle, 1-3 set, 4-6 prefix, 7 reserved) |
| op_daddr | input | 9 | Register address held in the operation's D field |
| op_dval | input | 32 | D operand value (contents of the register at `op_daddr`) |
| op_sval | input | 9 | Low nine bits of the S operand or immediate |
| next_valid | input | 1 | An instruction is at decode this cycle |
| next_addr | input | 9 | Fetch address of that instruction |
| next_insn | input | 32 | Instruction word before patching |
| patched_insn | output | 32 | Instruction word after patching |
| result_addr | output | 9 | Register address the instruction's result goes to |
| wr_en | output | 1 | Register-file write strobe from a set operation |
| wr_addr | output | 9 | Register-file write address |
| wr_data | output | 32 | Register-file write data |
| patch_hazard | output | 1 | Fetched word was rewritten too recently to execute |

## Verification
The hardest situation to reach is a prefix that stays armed across idle cycles and is then consumed in the same cycle that a fresh prefix arrives. This is the case where clearing and re-arming compete. The bench gets there by arming a prefix, holding `next_valid` low for two clocks, and then presenting an instruction together with a second prefix code. It then checks that the first patch is applied, that the second patch lands on the following word, and that a third word passes untouched. The hazard window edges are reached by fetching the rewritten address in each of the five clocks after a set.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

  parameter int unsigned XLEN   = 32;
  parameter int unsigned FW     = 9;
  parameter int unsigned S_LSB  = 0;
  parameter int unsigned D_LSB  = 9;
  parameter int unsigned OP_LSB = 19;

  typedef enum logic [2:0] {
    OPK_IDLE  = 3'd0,
    OPK_SET_S = 3'd1,
    OPK_SET_D = 3'd2,
    OPK_SET_O = 3'd3,
    OPK_ALT_S = 3'd4,
    OPK_ALT_D = 3'd5,
    OPK_ALT_R = 3'd6,
    OPK_RSVD  = 3'd7
  } opk_e;

  typedef enum logic [1:0] {
    PFX_S = 2'd0,
    PFX_D = 2'd1,
    PFX_R = 2'd2
  } pfx_e;

  // Overwrite one 9-bit field of a word.
  function automatic logic [XLEN-1:0] put_field(input logic [XLEN-1:0] w,
                                                input int unsigned lsb,
                                                input logic [FW-1:0] v);
    logic [XLEN-1:0] r;
    r = w;
    r[lsb +: FW] = v;
    return r;
  endfunction

  // Register-address sum; carry out of the field is dropped.
  function automatic logic [FW-1:0] addr_sum(input logic [FW-1:0] a,
                                             input logic [FW-1:0] b);
    logic [FW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[FW-1:0];
  endfunction

  function automatic logic is_set(input logic [2:0] k);
    return (k == OPK_SET_S) || (k == OPK_SET_D) || (k == OPK_SET_O);
  endfunction

  function automatic logic is_pfx(input logic [2:0] k);
    return (k == OPK_ALT_S) || (k == OPK_ALT_D) || (k == OPK_ALT_R);
  endfunction

endpackage

// File: rtl/fpu_setter.sv
module fpu_setter
  import fpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_code,
  input  logic [FW-1:0]   op_daddr,
  input  logic [XLEN-1:0] op_dval,
  input  logic [FW-1:0]   op_sval,
  output logic            wr_en,
  output logic [FW-1:0]   wr_addr,
  output logic [XLEN-1:0] wr_data
);

  logic [XLEN-1:0] nxt_data;

  always_comb begin
    unique case (op_code)
      OPK_SET_S: nxt_data = put_field(op_dval, S_LSB,  op_sval);
      OPK_SET_D: nxt_data = put_field(op_dval, D_LSB,  op_sval);
      OPK_SET_O: nxt_data = put_field(op_dval, OP_LSB, op_sval);
      default:   nxt_data = op_dval;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= is_set(op_code);
      if (is_set(op_code)) begin
        wr_addr <= op_daddr;
        wr_data <= nxt_data;
      end
    end
  end

endmodule

// File: rtl/fpu_prefix.sv
module fpu_prefix
  import fpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_code,
  input  logic [FW-1:0]   op_dlow,
  input  logic [FW-1:0]   op_sval,
  input  logic            next_valid,
  input  logic [XLEN-1:0] next_insn,
  output logic [XLEN-1:0] patched_insn,
  output logic [FW-1:0]   result_addr,
  output logic            armed,
  output logic            arm_evt,
  output logic            consume_evt
);

  pfx_e          kind_q;
  logic [FW-1:0] sum_q;
  pfx_e          kind_d;

  assign arm_evt     = is_pfx(op_code);
  assign consume_evt = armed && next_valid;

  always_comb begin
    unique case (op_code)
      OPK_ALT_D: kind_d = PFX_D;
      OPK_ALT_R: kind_d = PFX_R;
      default:   kind_d = PFX_S;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      kind_q <= PFX_S;
      sum_q  <= '0;
    end else if (arm_evt) begin
      armed  <= 1'b1;
      kind_q <= kind_d;
      sum_q  <= addr_sum(op_dlow, op_sval);
    end else if (next_valid) begin
      armed  <= 1'b0;
    end
  end

  always_comb begin
    patched_insn = next_insn;
    result_addr  = next_insn[D_LSB +: FW];
    if (armed) begin
      unique case (kind_q)
        PFX_S: patched_insn = put_field(next_insn, S_LSB, sum_q);
        PFX_D: begin
          patched_insn = put_field(next_insn, D_LSB, sum_q);
          result_addr  = sum_q;
        end
        default: result_addr = sum_q;
      endcase
    end
  end

endmodule

// File: rtl/fpu_hazard.sv
module fpu_hazard
  import fpu_pkg::*;
#(
  parameter int unsigned HAZ_CLKS = 4,
  localparam int unsigned CW = $clog2(HAZ_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_addr,
  input  logic          next_valid,
  input  logic [FW-1:0] next_addr,
  output logic          hazard
);

  logic [CW-1:0] cnt_q;
  logic [FW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (load) begin
      cnt_q  <= CW'(HAZ_CLKS);
      addr_q <= load_addr;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign hazard = next_valid && (cnt_q != '0) && (next_addr == addr_q);

endmodule

// File: rtl/field_patch_unit.sv
module field_patch_unit
  import fpu_pkg::*;
#(
  parameter int unsigned HAZ_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_code,
  input  logic [8:0]  op_daddr,
  input  logic [31:0] op_dval,
  input  logic [8:0]  op_sval,
  input  logic        next_valid,
  input  logic [8:0]  next_addr,
  input  logic [31:0] next_insn,
  output logic [31:0] patched_insn,
  output logic [8:0]  result_addr,
  output logic        wr_en,
  output logic [8:0]  wr_addr,
  output logic [31:0] wr_data,
  output logic        patch_hazard
);

  logic set_issue;
  logic pfx_armed;
  logic pfx_arm;
  logic pfx_consume;

  assign set_issue = is_set(op_code);

  fpu_setter u_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .op_daddr (op_daddr),
    .op_dval  (op_dval),
    .op_sval  (op_sval),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  fpu_prefix u_pfx (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_code      (op_code),
    .op_dlow      (op_dval[FW-1:0]),
    .op_sval      (op_sval),
    .next_valid   (next_valid),
    .next_insn    (next_insn),
    .patched_insn (patched_insn),
    .result_addr  (result_addr),
    .armed        (pfx_armed),
    .arm_evt      (pfx_arm),
    .consume_evt  (pfx_consume)
  );

  fpu_hazard #(.HAZ_CLKS(HAZ_CLKS)) u_haz (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (set_issue),
    .load_addr  (op_daddr),
    .next_valid (next_valid),
    .next_addr  (next_addr),
    .hazard     (patch_hazard)
  );

endmodule

// File: rtl/fpu_chk.sv
module fpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        set_issue,
  input logic        pfx_armed,
  input logic        pfx_arm,
  input logic        pfx_consume,
  input logic        next_valid,
  input logic [31:0] next_insn,
  input logic [31:0] patched_insn,
  input logic [8:0]  result_addr,
  input logic        wr_en,
  input logic        patch_hazard
);

  // R4
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(set_issue));

  // R4
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_issue |=> wr_en);

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_consume && !pfx_arm) |=> !pfx_armed);

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_arm |=> pfx_armed);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_armed && !next_valid) |=> pfx_armed);

  // R8
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_armed |-> (patched_insn == next_insn && result_addr == next_insn[17:9]));

  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    patched_insn[31:18] == next_insn[31:18]);

  // R10
  hazard_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hazard |-> next_valid);

endmodule

bind field_patch_unit fpu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_issue    (set_issue),
  .pfx_armed    (pfx_armed),
  .pfx_arm      (pfx_arm),
  .pfx_consume  (pfx_consume),
  .next_valid   (next_valid),
  .next_insn    (next_insn),
  .patched_insn (patched_insn),
  .result_addr  (result_addr),
  .wr_en        (wr_en),
  .patch_hazard (patch_hazard)
);

// File: tb/tb_field_patch_unit.sv
`timescale 1ns/1ps
module tb_field_patch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [8:0]  op_daddr = '0;
  logic [31:0] op_dval = '0;
  logic [8:0]  op_sval = '0;
  logic        next_valid = 1'b0;
  logic [8:0]  next_addr = '0;
  logic [31:0] next_insn = '0;
  logic [31:0] patched_insn;
  logic [8:0]  result_addr;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        patch_hazard;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  field_patch_unit dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_daddr(op_daddr),
    .op_dval(op_dval), .op_sval(op_sval), .next_valid(next_valid),
    .next_addr(next_addr), .next_insn(next_insn), .patched_insn(patched_insn),
    .result_addr(result_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .patch_hazard(patch_hazard)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ins9(input logic [31:0] w, input int pos, input logic [8:0] v);
    logic [31:0] m;
    m = 32'h1FF << pos;
    return (w & ~m) | ((32'(v) << pos) & m);
  endfunction

  function automatic logic [8:0] sum9(input logic [31:0] d, input logic [8:0] s);
    int t;
    t = (int'(d & 32'h1FF) + int'(s)) % 512;
    return 9'(t);
  endfunction

  task automatic idle_ops();
    op_code = 3'd0; next_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [8:0]  sm;
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk("R11 wr_en", 32'(wr_en), 0);
    chk("R11 hazard", 32'(patch_hazard), 0);
    next_insn = 32'hDEADBEEF; #1;
    chk("R11 no prefix", patched_insn, 32'hDEADBEEF);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 sweep of set operations
    for (int k = 1; k <= 3; k++) begin
      for (int v = 0; v < 512; v += 29) begin
        w = 32'hA5C3_0F69 ^ (32'(v) * 32'h0101_0101);
        op_code = 3'(k); op_daddr = 9'(511 - v); op_dval = w; op_sval = 9'(v);
        @(negedge clk);
        op_code = 3'd0;
        chk("R4 strobe", 32'(wr_en), 1);
        chk("R1 addr", 32'(wr_addr), 32'(511 - v));
        if (k == 1) chk("R1 set-S", wr_data, ins9(w, 0, 9'(v)));
        if (k == 2) chk("R2 set-D", wr_data, ins9(w, 9, 9'(v)));
        if (k == 3) chk("R3 set-opcode", wr_data, ins9(w, 19, 9'(v)));
        @(negedge clk);
        chk("R4 single clock", 32'(wr_en), 0);
      end
    end

    // R4 non-set codes never write
    for (int k = 4; k <= 7; k++) begin
      op_code = 3'(k); op_dval = 32'h1234; op_sval = 9'h55;
      @(negedge clk);
      op_code = 3'd0;
      chk("R4 no write", 32'(wr_en), 0);
      next_valid = 1'b1; next_insn = 32'h0; @(negedge clk); next_valid = 1'b0;
    end

    // R5 R6 R7 prefix sweep, with carry wrap
    for (int k = 4; k <= 6; k++) begin
      for (int d = 0; d < 512; d += 97) begin
        for (int s = 0; s < 512; s += 131) begin
          w = 32'h0F5A_3C96 ^ (32'(d) << 11) ^ 32'(s);
          op_code = 3'(k); op_dval = 32'hFFFF_FE00 | 32'(d); op_sval = 9'(s);
          sm = sum9(32'(d), 9'(s));
          @(negedge clk);
          op_code = 3'd0; next_valid = 1'b1; next_insn = w; #1;
          if (k == 4) chk("R5 alter-S", patched_insn, ins9(w, 0, sm));
          if (k == 5) chk("R6 alter-D", patched_insn, ins9(w, 9, sm));
          if (k == 6) begin
            chk("R7 alter-R addr", 32'(result_addr), 32'(sm));
            chk("R7 word kept", patched_insn, w);
          end
          @(negedge clk);
          next_insn = ~w; #1;
          chk("R9 one-shot word", patched_insn, ~w);
          chk("R8 default result", 32'(result_addr), 32'((~w >> 9) & 32'h1FF));
          @(negedge clk);
          next_valid = 1'b0;
        end
      end
    end

    // R9 idle hold, cond=0 consume, re-arm in same cycle
    op_code = 3'd4; op_dval = 32'd300; op_sval = 9'd300;
    @(negedge clk); op_code = 3'd0;
    @(negedge clk); @(negedge clk);
    next_valid = 1'b1; next_insn = 32'h0004_0000; op_code = 3'd5; op_dval = 32'd7; op_sval = 9'd8; #1;
    chk("R9 held across idle", patched_insn, ins9(32'h0004_0000, 0, 9'd88));
    chk("R5 I bit kept", 32'(patched_insn[18]), 1);
    @(negedge clk); op_code = 3'd0; next_insn = 32'h0; #1;
    chk("R9 re-armed", patched_insn, ins9(32'h0, 9, 9'd15));
    @(negedge clk); #1;
    chk("R9 cleared", patched_insn, 32'h0);
    next_valid = 1'b0;

    // R8 reserved code does not patch
    op_code = 3'd7; op_dval = 32'd5; op_sval = 9'd5;
    @(negedge clk); op_code = 3'd0; next_valid = 1'b1; next_insn = 32'h7777_7777; #1;
    chk("R8 reserved", patched_insn, 32'h7777_7777);
    chk("R8 result", 32'(result_addr), 32'h1BB);
    @(negedge clk); next_valid = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);

    // R10 hazard window
    op_code = 3'd2; op_daddr = 9'h0AB; op_dval = 32'h0; op_sval = 9'h1;
    @(negedge clk); op_code = 3'd0;
    for (int c = 1; c <= 6; c++) begin
      next_valid = 1'b1; next_addr = 9'h0AB; #1;
      chk("R10 window", 32'(patch_hazard), (c <= 4) ? 32'd1 : 32'd0);
      next_addr = 9'h0AC; #1;
      chk("R10 other addr", 32'(patch_hazard), 0);
      next_valid = 1'b0; next_addr = 9'h0AB; #1;
      chk("R10 no fetch", 32'(patch_hazard), 0);
      @(negedge clk);
    end

    idle_ops();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule